// File: doc/BRIEF.md
# Tiered Thermal Channel Guard

This block protects a four-channel line feeder against overheating. It takes three temperature tiers from an analog sensor. Each tier arrives as a synchronous "above" flag and a "released" flag, with the hysteresis already applied. The block also takes the current-limit, activated and switch-off state of each channel. It keeps one enable bit per channel that a driver must see high before it can switch on.

The lowest tier (110 degrees) only stops new activation requests from being accepted. Requests already queued are not touched. The middle tier (130 degrees) knocks out only the activated channels that are in current limit, and latches them off. The top tier (160 degrees) pulls every enable bit low and latches the activated channels off. Each tier clears at its own lower point: 100, 120 and 150 degrees. When the power-on sequencer is enabled, the middle tier clears at 100 degrees instead of 120. A latched-off channel comes back only after a switch-off command for that channel, or after a reset.

Top module: `thermal_tier_guard`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises:
  - every bit of `tor` reads 1;
  - `accept_new` reads 1;
  - `t_stat` reads 0.
- R2: In the cycle after `hot1_above` is high, `accept_new` reads 0. It stays 0 until the cycle after a clock edge where `hot1_rel` is high and `hot1_above` is low. A high `hot1_above` outranks a high `hot1_rel`.
- R3: Suppose `hot2_above`, `lim[i]` and `act[i]` are all high at a clock edge, and `off_cmd[i]` is low. Then `tor[i]` (bit i = channel i, 1 = enabled) reads 0 after that edge. Channels that miss any of these conditions keep their `tor` bit.
- R4: A `tor` bit that the 130 or 160 degree tier has cleared stays 0 while the temperature falls. It returns to 1 only at a clock edge where that channel's `off_cmd` bit is high, or on reset.
- R5: At a clock edge where `off_cmd[i]` is high, `tor[i]` becomes 1. This holds even when a 130 degree trip hits channel i at the same edge.
- R6: After a 130 degree trip of channel i, `drv_en[i]` stays 0 until a release edge, even if the channel is re-armed earlier. The release edge is one where `hot2_rel` is high (with `seq_en` low) or `hot1_rel` is high (with `seq_en` high).
- R7: At an edge where `hot3_above` is high, the latched `tor` bit of every channel with `act` high is cleared. While the top tier is held, all `tor` outputs read 0. When it clears, the bits of channels that were not activated read 1 again.
- R8: `t_stat` reads 1 from the cycle after `hot3_above` is high until the cycle after an edge where `hot3_rel` is high and `hot3_above` is low.
- R9: `drv_en[i]` reads 1 exactly when `act[i]` is 1, `tor[i]` is 1 and channel i has no unreleased 130 degree trip.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seq_en | input | 1 | Power-on sequencer enabled (moves the 130 degree release point to 100 degrees) |
| hot1_above | input | 1 | Temperature at or above 110 degrees |
| hot1_rel | input | 1 | Temperature down to 100 degrees |
| hot2_above | input | 1 | Temperature at or above 130 degrees |
| hot2_rel | input | 1 | Temperature down to 120 degrees |
| hot3_above | input | 1 | Temperature at or above 160 degrees |
| hot3_rel | input | 1 | Temperature down to 150 degrees |
| lim | input | NCH | Per-channel current-limit indication |
| act | input | NCH | Per-channel activated state |
| off_cmd | input | NCH | Per-channel switch-off command |
| accept_new | output | 1 | New activation requests may be accepted |
| tor | output | NCH | Per-channel thermal enable bits |
| drv_en | output | NCH | Per-channel driver switch-on permission |
| t_stat | output | 1 | Top tier active |

## Verification
The assertions assume that a tier's "above" and "released" flags are never high in the same cycle. The analog hysteresis makes this true, and the logic resolves such a clash toward "above" anyway. They also assume that all inputs are synchronous to `clk`. The random stimulus enforces the first point by drawing "released" only in cycles where "above" is low. It drives every input at the falling clock edge, so no input changes near the sampling edge. The directed cases place a switch-off command and a trip on the same channel in the same cycle. They also exercise both release points of the middle tier.

// File: rtl/thermal_tier_guard.sv
module thermal_tier_guard #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           seq_en,
  input  logic           hot1_above,
  input  logic           hot1_rel,
  input  logic           hot2_above,
  input  logic           hot2_rel,
  input  logic           hot3_above,
  input  logic           hot3_rel,
  input  logic [NCH-1:0] lim,
  input  logic [NCH-1:0] act,
  input  logic [NCH-1:0] off_cmd,
  output logic           accept_new,
  output logic [NCH-1:0] tor,
  output logic [NCH-1:0] drv_en,
  output logic           t_stat
);

  logic           blk_q;
  logic           top_q;
  logic [NCH-1:0] tor_q;
  logic [NCH-1:0] trip_q;
  logic [NCH-1:0] mid_hit;
  logic           mid_free;

  assign mid_hit  = {NCH{hot2_above}} & lim & act;
  assign mid_free = seq_en ? hot1_rel : hot2_rel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      blk_q <= 1'b0;
      top_q <= 1'b0;
    end else begin
      if (hot1_above)    blk_q <= 1'b1;
      else if (hot1_rel) blk_q <= 1'b0;
      if (hot3_above)    top_q <= 1'b1;
      else if (hot3_rel) top_q <= 1'b0;
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tor_q[i]  <= 1'b1;
        trip_q[i] <= 1'b0;
      end else begin
        if (off_cmd[i])                            tor_q[i] <= 1'b1;
        else if (mid_hit[i] || (hot3_above && act[i])) tor_q[i] <= 1'b0;
        if (mid_hit[i] && !off_cmd[i]) trip_q[i] <= 1'b1;
        else if (mid_free)             trip_q[i] <= 1'b0;
      end
    end
  end

  assign accept_new = ~blk_q;
  assign t_stat     = top_q;
  assign tor        = top_q ? '0 : tor_q;
  assign drv_en     = act & tor & ~trip_q;

  p_reset_state_r1: assert property (@(posedge clk) $rose(rst_n) |-> (tor_q == '1 && !blk_q && !top_q))
    else $error("p_reset_state_r1");

  p_block_new_r2: assert property (@(posedge clk) disable iff (!rst_n) hot1_above |=> !accept_new)
    else $error("p_block_new_r2");

  p_mid_trip_r3: assert property (@(posedge clk) disable iff (!rst_n)
    |(mid_hit & ~off_cmd) |=> (tor_q & $past(mid_hit & ~off_cmd)) == '0)
    else $error("p_mid_trip_r3");

  p_latched_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
    |(~tor_q & ~off_cmd) |=> (tor_q & $past(~tor_q & ~off_cmd)) == '0)
    else $error("p_latched_low_r4");

  p_off_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
    |off_cmd |=> (tor_q & $past(off_cmd)) == $past(off_cmd))
    else $error("p_off_wins_r5");

  p_trip_holds_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (|(mid_hit & ~off_cmd) && !mid_free) |=> (trip_q & $past(mid_hit & ~off_cmd)) == $past(mid_hit & ~off_cmd))
    else $error("p_trip_holds_r6");

  p_top_clear_r7: assert property (@(posedge clk) disable iff (!rst_n) hot3_above |=> tor == '0)
    else $error("p_top_clear_r7");

  p_top_set_r8: assert property (@(posedge clk) disable iff (!rst_n) hot3_above |=> t_stat)
    else $error("p_top_set_r8");

  p_top_release_r8: assert property (@(posedge clk) disable iff (!rst_n) (hot3_rel && !hot3_above) |=> !t_stat)
    else $error("p_top_release_r8");

endmodule

// File: tb/tb_thermal_tier_guard.sv
module tb_thermal_tier_guard;
  localparam int NCH = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic seq_en = 1'b0;
  logic hot1_above = 1'b0, hot1_rel = 1'b0;
  logic hot2_above = 1'b0, hot2_rel = 1'b0;
  logic hot3_above = 1'b0, hot3_rel = 1'b0;
  logic [NCH-1:0] lim = '0, act = '0, off_cmd = '0;
  logic accept_new, t_stat;
  logic [NCH-1:0] tor, drv_en;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  logic           m_blk, m_top;
  logic [NCH-1:0] m_tor, m_trip;

  always #5 clk = ~clk;

  thermal_tier_guard #(.NCH(NCH)) dut (
    .clk(clk), .rst_n(rst_n), .seq_en(seq_en),
    .hot1_above(hot1_above), .hot1_rel(hot1_rel),
    .hot2_above(hot2_above), .hot2_rel(hot2_rel),
    .hot3_above(hot3_above), .hot3_rel(hot3_rel),
    .lim(lim), .act(act), .off_cmd(off_cmd),
    .accept_new(accept_new), .tor(tor), .drv_en(drv_en), .t_stat(t_stat)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_blk <= 1'b0; m_top <= 1'b0; m_tor <= '1; m_trip <= '0;
    end else begin
      m_blk <= hot1_above ? 1'b1 : (hot1_rel ? 1'b0 : m_blk);
      m_top <= hot3_above ? 1'b1 : (hot3_rel ? 1'b0 : m_top);
      for (int i = 0; i < NCH; i++) begin
        logic hit;
        hit = hot2_above && lim[i] && act[i];
        if (off_cmd[i]) m_tor[i] <= 1'b1;
        else if (hit || (hot3_above && act[i])) m_tor[i] <= 1'b0;
        if (hit && !off_cmd[i]) m_trip[i] <= 1'b1;
        else if (seq_en ? hot1_rel : hot2_rel) m_trip[i] <= 1'b0;
      end
    end
  end

  function automatic logic [NCH-1:0] exp_tor();
    return m_top ? '0 : m_tor;
  endfunction

  function automatic logic [NCH-1:0] exp_drv();
    return act & exp_tor() & ~m_trip;
  endfunction

  task automatic chk(input string req, input logic [NCH-1:0] got, input logic [NCH-1:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", req, got, exp, $time);
    end
  endtask

  task automatic check_all();
    chk("R2 accept_new", {{(NCH-1){1'b0}}, accept_new}, {{(NCH-1){1'b0}}, ~m_blk});
    chk("R3/R4/R7 tor", tor, exp_tor());
    chk("R8 t_stat", {{(NCH-1){1'b0}}, t_stat}, {{(NCH-1){1'b0}}, m_top});
    chk("R6/R9 drv_en", drv_en, exp_drv());
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    check_all();
  endtask

  task automatic quiet();
    hot1_above = 0; hot1_rel = 0; hot2_above = 0; hot2_rel = 0;
    hot3_above = 0; hot3_rel = 0; off_cmd = '0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    @(negedge clk);
    @(negedge clk);
    chk("R1 reset tor", tor, '1);
    chk("R1 reset accept_new", {{(NCH-1){1'b0}}, accept_new}, {{(NCH-1){1'b0}}, 1'b1});
    chk("R1 reset t_stat", {{(NCH-1){1'b0}}, t_stat}, '0);
    rst_n = 1'b1;
    step();
    chk("R1 after reset tor", tor, '1);

    act = 4'b0011; lim = 4'b0011; hot2_above = 1; off_cmd = 4'b0001;
    step();
    chk("R5 off wins tor0", {3'b0, tor[0]}, 4'b0001);
    chk("R3 trip tor1", {3'b0, tor[1]}, 4'b0000);
    quiet(); seq_en = 1;
    step();
    off_cmd = 4'b0010;
    step();
    off_cmd = '0;
    chk("R5 rearm tor1", {3'b0, tor[1]}, 4'b0001);
    chk("R6 still held drv1", {3'b0, drv_en[1]}, 4'b0000);
    hot2_rel = 1;
    step();
    chk("R6 seq_en ignores hot2_rel", {3'b0, drv_en[1]}, 4'b0000);
    hot2_rel = 0; hot1_rel = 1;
    step();
    chk("R6 hot1_rel frees drv1", {3'b0, drv_en[1]}, 4'b0001);
    quiet(); seq_en = 0;

    act = 4'b0101; lim = '0; hot3_above = 1;
    step();
    chk("R7 all tor low", tor, 4'b0000);
    chk("R8 t_stat set", {3'b0, t_stat}, 4'b0001);
    hot3_above = 0; hot3_rel = 1;
    step();
    chk("R7 inactive return", tor, 4'b1010);
    chk("R8 t_stat clear", {3'b0, t_stat}, 4'b0000);
    quiet(); off_cmd = '1;
    step();
    quiet();

    for (int n = 0; n < 3000; n++) begin
      seq_en     = ($urandom % 8) == 0 ? ~seq_en : seq_en;
      hot1_above = ($urandom % 10) == 0;
      hot1_rel   = !hot1_above && ($urandom % 6) == 0;
      hot2_above = ($urandom % 12) == 0;
      hot2_rel   = !hot2_above && ($urandom % 6) == 0;
      hot3_above = ($urandom % 20) == 0;
      hot3_rel   = !hot3_above && ($urandom % 6) == 0;
      lim        = NCH'($urandom);
      act        = NCH'($urandom | $urandom);
      off_cmd    = NCH'($urandom & $urandom & $urandom);
      step();
    end
    finish_run();
  end
endmodule